// File: doc/BRIEF.md
# SPI Buffer Command Sequencer

This block runs one SPI transaction per command out of a shared 512-byte buffer. The host fills the buffer through a simple byte port. The first two bytes hold a big-endian 16-bit header: an opcode, a dual-lane flag and a byte count. Any transmit payload follows the header, starting at byte 2. The host then writes a command word that gives a command code, a profile index and a slave-select index.

The sequencer checks the header. For a data opcode it asserts the selected chip select and clocks the bytes MSB first, one half SPI clock period per external tick. Each received byte is written back into the buffer, starting at byte 0. When the transfer ends it raises a one-cycle done pulse, or an invalid-control pulse if the header was rejected. A separate clock generator supplies the ticks, and it reads the latched profile index from the block to choose its rate.

Top module: `spi_seq_top`

## Requirements
- R1: After reset, busy is 0, every chip select is high (inactive), sck is 0, and neither done nor invalid is pulsing.
- R2: Command code 1 (start now) with header opcode 2 (write-only) shifts count bytes from buffer offset 2 upward onto io0, MSB first. Each bit is valid at a rising sck edge. The block then pulses done once and drops busy.
- R3: Opcode 3 (read-only) samples io1 at each rising sck edge and stores the received bytes at buffer offsets 0 upward. A count of up to 512 is accepted.
- R4: Opcode 1 (read-write) transmits from offset 2 and stores received bytes from offset 0 in the same transfer. Transmit bytes not yet reached are left unchanged.
- R5: When header bit 11 is set, each rising sck edge moves two bits. The higher bit is on io1 and the lower bit is on io0, so a byte takes 4 sck periods. This applies to write-only and read-only transfers.
- R6: A header is rejected if its count is 0, its opcode is 5 to 7, it combines the dual flag with read-write, or its count exceeds 510 (non-read opcodes) or 512 (read-only). A rejected header gives one invalid pulse, no done pulse and no chip-select activity. A count of exactly 510 or 512 respectively is accepted.
- R7: Opcodes 0 (sleep) and 4 (set-interrupt) complete at once with a done pulse and no bus activity.
- R8: The chip select goes active exactly one tick before the first rising sck edge. It is released exactly one tick after the last falling edge. sck is low whenever no chip select is active.
- R9: Command code 2 (start on trigger) makes the block busy but leaves the bus idle until a trigger pulse arrives. The transfer then runs as for a start-now command.
- R10: Command code 3 (halt) ends the transfer at the next byte boundary. No done pulse is given, busy drops and the chip select is released.
- R11: Command code 4 (flush) stops the transfer on the next clock edge, releasing the chip select with no done pulse and no further sck edges.
- R12: Command bits 15:12 select which chip-select line (active low) is driven. Command bits 11:8 appear on prof_sel and stay there.
- R13: While busy, command codes other than halt and flush are ignored.
- R14: sck changes only on a clock edge where tick was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Half SPI clock period enable |
| trig | input | 1 | External start trigger pulse |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | 16 | Command word: code 3:0, profile 11:8, slave 15:12 |
| host_we | input | 1 | Buffer byte write strobe (idle only) |
| host_addr | input | 9 | Buffer write address |
| host_wdata | input | 8 | Buffer write data |
| host_raddr | input | 9 | Buffer read address |
| host_rdata | output | 8 | Buffer read data (combinational) |
| busy | output | 1 | A command is executing |
| done_pulse | output | 1 | One-cycle command-complete event |
| inval_pulse | output | 1 | One-cycle rejected-header event |
| prof_sel | output | 4 | Latched profile index |
| sck | output | 1 | SPI clock, idle low |
| cs_n | output | 8 | Active-low chip selects |
| io0_o | output | 1 | Lane 0 output (MOSI) |
| io0_oe | output | 1 | Lane 0 output enable |
| io0_i | input | 1 | Lane 0 input (dual reads) |
| io1_o | output | 1 | Lane 1 output (dual writes) |
| io1_oe | output | 1 | Lane 1 output enable |
| io1_i | input | 1 | Lane 1 input (MISO) |

## Verification
The assertions assume that tick is a single-cycle pulse with at least one idle cycle between pulses. They also assume the host writes the buffer only while busy is low, and that the slave-select index is below the number of chip selects. The bench generates a tick on every second clock and fills the buffer only between transactions. Its command words use slave indices 0 to 3, and it changes the slave's input lanes only at observed falling sck edges or when the chip select is asserted.

// File: rtl/spi_seq_pkg.sv
`timescale 1ns/1ps
package spi_seq_pkg;
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_TRIG  = 3'd1,
        S_SETUP = 3'd2,
        S_SHIFT = 3'd3,
        S_HOLD  = 3'd4
    } seq_st_e;

    localparam logic [3:0] CMD_NOP   = 4'd0;
    localparam logic [3:0] CMD_GO    = 4'd1;
    localparam logic [3:0] CMD_TRIG  = 4'd2;
    localparam logic [3:0] CMD_HALT  = 4'd3;
    localparam logic [3:0] CMD_FLUSH = 4'd4;

    localparam logic [2:0] OP_SLEEP = 3'd0;
    localparam logic [2:0] OP_RW    = 3'd1;
    localparam logic [2:0] OP_WR    = 3'd2;
    localparam logic [2:0] OP_RD    = 3'd3;
    localparam logic [2:0] OP_IRQ   = 3'd4;

    localparam int HDR_BYTES = 2;
    localparam int CNT_W     = 11;
endpackage

// File: rtl/spi_seq_mem.sv
`timescale 1ns/1ps
module spi_seq_mem #(
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [7:0]    wd,
    input  logic [AW-1:0] ra_a,
    output logic [7:0]    rd_a,
    input  logic [AW-1:0] ra_b,
    output logic [7:0]    rd_b,
    output logic [15:0]   hdr
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[wa] <= wd;
    end

    assign rd_a = mem[ra_a];
    assign rd_b = mem[ra_b];
    // big-endian header: byte 0 is the high half
    assign hdr  = {mem[0], mem[1]};
endmodule

// File: rtl/spi_seq_hdr.sv
`timescale 1ns/1ps
module spi_seq_hdr
    import spi_seq_pkg::*;
#(
    parameter int BUF_BYTES = 512
) (
    input  logic [15:0]      hdr,
    output logic [2:0]       op,
    output logic             dual,
    output logic [CNT_W-1:0] cnt,
    output logic             is_data,
    output logic             ok
);
    localparam logic [CNT_W:0] LIM_RD = (CNT_W+1)'(BUF_BYTES);
    localparam logic [CNT_W:0] LIM_TX = (CNT_W+1)'(BUF_BYTES - HDR_BYTES);

    logic [CNT_W:0] lim;
    logic           unused_rsvd;

    assign op          = hdr[15:13];
    assign dual        = hdr[11];
    assign cnt         = hdr[CNT_W-1:0];
    assign unused_rsvd = hdr[12];

    always_comb begin
        is_data = (op == OP_RW) || (op == OP_WR) || (op == OP_RD);
        lim     = (op == OP_RD) ? LIM_RD : LIM_TX;
        if (op > OP_IRQ)
            ok = 1'b0;
        else if (!is_data)
            ok = 1'b1;
        else
            ok = (cnt != '0) && ({1'b0, cnt} <= lim) && !(dual && op == OP_RW);
    end
endmodule

// File: rtl/spi_seq_top.sv
`timescale 1ns/1ps
module spi_seq_top
    import spi_seq_pkg::*;
#(
    parameter int BUF_BYTES = 512,
    parameter int NUM_SS    = 8,
    localparam int AW = $clog2(BUF_BYTES),
    localparam int IW = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              trig,
    input  logic              cmd_we,
    input  logic [15:0]       cmd_wdata,
    input  logic              host_we,
    input  logic [AW-1:0]     host_addr,
    input  logic [7:0]        host_wdata,
    input  logic [AW-1:0]     host_raddr,
    output logic [7:0]        host_rdata,
    output logic              busy,
    output logic              done_pulse,
    output logic              inval_pulse,
    output logic [3:0]        prof_sel,
    output logic              sck,
    output logic [NUM_SS-1:0] cs_n,
    output logic              io0_o,
    output logic              io0_oe,
    input  logic              io0_i,
    output logic              io1_o,
    output logic              io1_oe,
    input  logic              io1_i
);
    typedef struct packed {
        seq_st_e       st;
        logic [IW-1:0] idx;
        logic [IW-1:0] cnt;
        logic [2:0]    step;
        logic          sck;
        logic [7:0]    tx;
        logic [7:0]    rx;
        logic [2:0]    op;
        logic          dual;
        logic [3:0]    ss;
        logic [3:0]    prof;
        logic          halt;
        logic          done;
        logic          inval;
    } seq_t;

    seq_t q, d;

    logic [2:0]       dec_op;
    logic             dec_dual, dec_data, dec_ok;
    logic [CNT_W-1:0] dec_cnt;
    logic [15:0]      hdr;
    logic [AW-1:0]    tx_ra, mem_wa;
    logic [7:0]       tx_rd, tx_byte, rx_in, tx_sh, mem_wd;
    logic             seq_we, mem_we, start, store, xfer;
    logic [2:0]       last_step;
    logic [3:0]       code;
    logic             unused_cmd;

    assign unused_cmd = ^{cmd_wdata[7:4], dec_cnt[CNT_W-1:IW]};

    spi_seq_mem #(.DEPTH(BUF_BYTES)) u_mem (
        .clk(clk), .we(mem_we), .wa(mem_wa), .wd(mem_wd),
        .ra_a(tx_ra), .rd_a(tx_rd), .ra_b(host_raddr), .rd_b(host_rdata),
        .hdr(hdr)
    );

    spi_seq_hdr #(.BUF_BYTES(BUF_BYTES)) u_hdr (
        .hdr(hdr), .op(dec_op), .dual(dec_dual), .cnt(dec_cnt),
        .is_data(dec_data), .ok(dec_ok)
    );

    // sequencer write wins; host writes only while idle
    assign mem_we = seq_we | host_we;
    assign mem_wa = seq_we ? q.idx[AW-1:0] : host_addr;
    assign mem_wd = seq_we ? q.rx : host_wdata;

    // first payload byte at the header's end, later ones one past the current index
    assign tx_ra   = (q.st == S_SHIFT) ? AW'(q.idx + IW'(HDR_BYTES + 1)) : AW'(HDR_BYTES);
    assign tx_byte = (q.op == OP_RD) ? 8'h00 : tx_rd;

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.inval   = 1'b0;
        seq_we    = 1'b0;
        start     = 1'b0;
        code      = cmd_wdata[3:0];
        last_step = q.dual ? 3'd3 : 3'd7;
        store     = (q.op == OP_RW) || (q.op == OP_RD);
        rx_in     = q.dual ? {q.rx[5:0], io1_i, io0_i} : {q.rx[6:0], io1_i};
        tx_sh     = q.dual ? {q.tx[5:0], 2'b00} : {q.tx[6:0], 1'b0};

        case (q.st)
            S_IDLE: if (cmd_we) begin
                if (code == CMD_GO || code == CMD_TRIG) begin
                    d.ss   = cmd_wdata[15:12];
                    d.prof = cmd_wdata[11:8];
                end
                if (code == CMD_GO)        start = 1'b1;
                else if (code == CMD_TRIG) d.st  = S_TRIG;
            end
            S_TRIG: if (trig) start = 1'b1;
            S_SETUP: if (tick) begin
                d.st  = S_SHIFT;
                d.sck = 1'b1;
                d.rx  = rx_in;
            end
            S_SHIFT: if (tick) begin
                if (!q.sck) begin
                    d.sck = 1'b1;
                    d.rx  = rx_in;
                end else begin
                    d.sck = 1'b0;
                    if (q.step == last_step) begin
                        seq_we = store;
                        d.idx  = q.idx + 1'b1;
                        d.step = '0;
                        d.tx   = tx_byte;
                        if (q.halt) begin
                            d.st   = S_IDLE;
                            d.halt = 1'b0;
                        end else if (d.idx == q.cnt) begin
                            d.st = S_HOLD;
                        end
                    end else begin
                        d.step = q.step + 1'b1;
                        d.tx   = tx_sh;
                    end
                end
            end
            S_HOLD: if (tick) begin
                d.st   = S_IDLE;
                d.done = 1'b1;
            end
            default: d.st = S_IDLE;
        endcase

        if (start) begin
            d.halt = 1'b0;
            if (!dec_ok) begin
                d.inval = 1'b1;
                d.st    = S_IDLE;
            end else if (!dec_data) begin
                d.done = 1'b1;
                d.st   = S_IDLE;
            end else begin
                d.st   = S_SETUP;
                d.op   = dec_op;
                d.dual = dec_dual;
                d.cnt  = dec_cnt[IW-1:0];
                d.idx  = '0;
                d.step = '0;
                d.sck  = 1'b0;
                d.tx   = (dec_op == OP_RD) ? 8'h00 : tx_rd;
            end
        end

        if (cmd_we && q.st != S_IDLE) begin
            if (code == CMD_HALT) begin
                if (q.st == S_SHIFT) d.halt = 1'b1;
                else begin
                    d.st   = S_IDLE;
                    d.done = 1'b0;
                end
            end
            if (code == CMD_FLUSH) begin
                d.st   = S_IDLE;
                d.sck  = 1'b0;
                d.idx  = '0;
                d.step = '0;
                d.halt = 1'b0;
                d.done = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign xfer        = (q.st == S_SETUP) || (q.st == S_SHIFT) || (q.st == S_HOLD);
    assign busy        = (q.st != S_IDLE);
    assign done_pulse  = q.done;
    assign inval_pulse = q.inval;
    assign prof_sel    = q.prof;
    assign sck         = q.sck;
    assign io1_o       = q.tx[7];
    assign io0_o       = q.dual ? q.tx[6] : q.tx[7];
    assign io0_oe      = xfer && !(q.dual && q.op == OP_RD);
    assign io1_oe      = xfer && q.dual && (q.op == OP_WR);

    for (genvar g = 0; g < NUM_SS; g++) begin : g_cs
        assign cs_n[g] = !(xfer && q.ss == 4'(g));
    end
endmodule

// File: rtl/spi_seq_chk.sv
`timescale 1ns/1ps
module spi_seq_chk #(
    parameter int NUM_SS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              busy,
    input logic              done_pulse,
    input logic              inval_pulse,
    input logic              sck,
    input logic [NUM_SS-1:0] cs_n
);
    // R8
    sck_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> !(&cs_n));

    // R12
    one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R1
    idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (&cs_n) && !sck);

    // R6
    inval_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inval_pulse |-> !done_pulse && !busy);

    // R2
    done_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> !busy);

    // R14
    sck_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sck) |-> $past(tick));
endmodule

bind spi_seq_top spi_seq_chk #(.NUM_SS(NUM_SS)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .busy(busy),
    .done_pulse(done_pulse), .inval_pulse(inval_pulse),
    .sck(sck), .cs_n(cs_n)
);

// File: tb/sim_spi_seq_top.sv
`timescale 1ns/1ps
module sim_spi_seq_top;
    logic        clk = 0, rst_n = 0, tick = 0, trig = 0, cmd_we = 0;
    logic [15:0] cmd_wdata = '0;
    logic        host_we = 0;
    logic [8:0]  host_addr = '0, host_raddr = '0;
    logic [7:0]  host_wdata = '0, host_rdata;
    logic        busy, done_pulse, inval_pulse, sck;
    logic [3:0]  prof_sel;
    logic [7:0]  cs_n;
    logic        io0_o, io0_oe, io1_o, io1_oe;
    logic        io0_i = 0, io1_i = 0;

    spi_seq_top u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .trig(trig),
        .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_raddr(host_raddr), .host_rdata(host_rdata),
        .busy(busy), .done_pulse(done_pulse), .inval_pulse(inval_pulse),
        .prof_sel(prof_sel), .sck(sck), .cs_n(cs_n),
        .io0_o(io0_o), .io0_oe(io0_oe), .io0_i(io0_i),
        .io1_o(io1_o), .io1_oe(io1_oe), .io1_i(io1_i)
    );

    always #10 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    int cyc = 0, tc = 0, viol = 0;
    int n_done = 0, n_inval = 0, nrise = 0;
    int t_csfall = 0, t_firstrise = 0, t_lastfall = 0, t_csrise = 0;
    bit first_seen = 0, dual_mode = 0, sck_prev = 0, cs_prev = 0;
    logic [7:0] cs_lines = '0;
    bit mbits[$];
    bit sbits[$];

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic present();
        if (dual_mode) begin
            io1_i = (sbits.size() > 0) ? sbits.pop_front() : 1'b0;
            io0_i = (sbits.size() > 0) ? sbits.pop_front() : 1'b0;
        end else begin
            io1_i = (sbits.size() > 0) ? sbits.pop_front() : 1'b0;
        end
    endtask

    // slave model and per-clock protocol monitor
    always @(negedge clk) begin
        bit cs_act;
        cyc++;
        cs_act = !(&cs_n);
        if (cs_act && !cs_prev) begin
            t_csfall = tc;
            first_seen = 0;
            present();
        end
        if (!cs_act && cs_prev) t_csrise = tc;
        if (cs_act) cs_lines = cs_lines | ~cs_n;
        if (sck && !sck_prev) begin
            nrise++;
            if (!first_seen) begin
                t_firstrise = tc;
                first_seen = 1;
            end
            if (dual_mode) begin
                mbits.push_back(io1_o);
                mbits.push_back(io0_o);
            end else mbits.push_back(io0_o);
        end
        if (!sck && sck_prev) begin
            t_lastfall = tc;
            present();
        end
        if (sck && !cs_act) viol++;
        if (done_pulse && busy) viol++;
        if ((sck != sck_prev) && !tick && rst_n) viol++;
        if (done_pulse) n_done++;
        if (inval_pulse) n_inval++;
        if (tick) tc++;
        tick = (cyc % 2 == 0);
        sck_prev = sck;
        cs_prev = cs_act;
    end

    task automatic clear_obs();
        mbits.delete();
        sbits.delete();
        n_done = 0; n_inval = 0; nrise = 0; cs_lines = '0;
    endtask

    task automatic put_buf(int a, logic [7:0] v);
        @(negedge clk);
        host_we = 1; host_addr = 9'(a); host_wdata = v;
    endtask

    task automatic end_buf();
        @(negedge clk);
        host_we = 0;
    endtask

    task automatic put_hdr(logic [2:0] op, bit dl, int cnt);
        logic [10:0] c;
        c = 11'(cnt);
        put_buf(0, {op, 1'b0, dl, c[10:8]});
        put_buf(1, c[7:0]);
    endtask

    task automatic get_buf(int a, output logic [7:0] v);
        @(negedge clk);
        host_raddr = 9'(a);
        #1 v = host_rdata;
    endtask

    task automatic issue(logic [3:0] code, logic [3:0] ss, logic [3:0] prof);
        @(negedge clk);
        cmd_we = 1; cmd_wdata = {ss, prof, 4'h0, code};
        @(negedge clk);
        cmd_we = 0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [7:0] mbyte(int k);
        logic [7:0] b;
        for (int i = 0; i < 8; i++) b[7-i] = mbits[8*k+i];
        return b;
    endfunction

    task automatic push_slave(logic [7:0] b);
        for (int i = 7; i >= 0; i--) sbits.push_back(b[i]);
    endtask

    initial begin
        #(20 * 190000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [7:0] v;
        int bad;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "busy", busy, 0);
        chk("R1", "cs_n", cs_n, 8'hFF);
        chk("R1", "sck+events", {sck, done_pulse, inval_pulse}, 0);

        // R2 write-only, slave 2, profile 5
        clear_obs(); dual_mode = 0;
        put_hdr(3'd2, 0, 3);
        put_buf(2, 8'hA5); put_buf(3, 8'h3C); put_buf(4, 8'hF0); end_buf();
        issue(4'd1, 4'd2, 4'd5);
        wait_idle();
        chk("R2", "bit count", mbits.size(), 24);
        chk("R2", "byte0", mbyte(0), 8'hA5);
        chk("R2", "byte1", mbyte(1), 8'h3C);
        chk("R2", "byte2", mbyte(2), 8'hF0);
        chk("R2", "done/inval", n_done * 10 + n_inval, 10);
        chk("R12", "cs line", cs_lines, 8'h04);
        chk("R12", "profile", prof_sel, 5);
        chk("R8", "cs lead ticks", t_firstrise - t_csfall, 1);
        chk("R8", "cs trail ticks", t_csrise - t_lastfall, 1);

        // R3 read-only
        clear_obs();
        put_hdr(3'd3, 0, 4); end_buf();
        push_slave(8'h81); push_slave(8'h7E); push_slave(8'h55); push_slave(8'hC3);
        issue(4'd1, 4'd0, 4'd0);
        wait_idle();
        get_buf(0, v); chk("R3", "rx0", v, 8'h81);
        get_buf(1, v); chk("R3", "rx1", v, 8'h7E);
        get_buf(2, v); chk("R3", "rx2", v, 8'h55);
        get_buf(3, v); chk("R3", "rx3", v, 8'hC3);
        chk("R3", "done", n_done, 1);

        // R4 read-write
        clear_obs();
        put_hdr(3'd1, 0, 2); put_buf(2, 8'h12); put_buf(3, 8'h34); put_buf(4, 8'h77); end_buf();
        push_slave(8'hAB); push_slave(8'hCD);
        issue(4'd1, 4'd1, 4'd0);
        wait_idle();
        chk("R4", "tx0", mbyte(0), 8'h12);
        chk("R4", "tx1", mbyte(1), 8'h34);
        get_buf(0, v); chk("R4", "rx0", v, 8'hAB);
        get_buf(1, v); chk("R4", "rx1", v, 8'hCD);
        get_buf(4, v); chk("R4", "untouched", v, 8'h77);

        // R5 dual write
        clear_obs(); dual_mode = 1;
        put_hdr(3'd2, 1, 2); put_buf(2, 8'hB4); put_buf(3, 8'h69); end_buf();
        issue(4'd1, 4'd0, 4'd0);
        wait_idle();
        chk("R5", "dual rises", nrise, 8);
        chk("R5", "dual tx0", mbyte(0), 8'hB4);
        chk("R5", "dual tx1", mbyte(1), 8'h69);

        // R5 dual read
        clear_obs();
        put_hdr(3'd3, 1, 2); end_buf();
        push_slave(8'h9C); push_slave(8'h3A);
        issue(4'd1, 4'd0, 4'd0);
        wait_idle();
        get_buf(0, v); chk("R5", "dual rx0", v, 8'h9C);
        get_buf(1, v); chk("R5", "dual rx1", v, 8'h3A);
        chk("R5", "dual read rises", nrise, 8);
        dual_mode = 0;

        // R6 rejected headers
        begin
            logic [2:0] ops [5] = '{3'd2, 3'd5, 3'd1, 3'd2, 3'd3};
            bit         dls [5] = '{0, 0, 1, 0, 0};
            int         cns [5] = '{0, 1, 2, 511, 513};
            for (int k = 0; k < 5; k++) begin
                clear_obs();
                put_hdr(ops[k], dls[k], cns[k]); end_buf();
                issue(4'd1, 4'd0, 4'd0);
                wait_idle();
                chk("R6", $sformatf("reject case %0d inval/done/cs", k),
                    n_inval * 100 + n_done * 10 + int'(cs_lines != 0), 100);
            end
        end

        // R7 sleep and set-interrupt
        for (int k = 0; k < 2; k++) begin
            clear_obs();
            put_hdr(k == 0 ? 3'd0 : 3'd4, 0, 0); end_buf();
            issue(4'd1, 4'd0, 4'd0);
            wait_idle();
            chk("R7", "done no bus", n_done * 10 + int'(cs_lines != 0), 10);
        end

        // R6 boundary: 510-byte write accepted
        clear_obs();
        put_hdr(3'd2, 0, 510);
        for (int i = 0; i < 510; i++) put_buf(2 + i, 8'(i * 7));
        end_buf();
        issue(4'd1, 4'd0, 4'd0);
        wait_idle();
        chk("R6", "510 write bits", mbits.size(), 510 * 8);
        bad = 0;
        for (int i = 0; i < 510; i++) if (mbits.size() >= 8 * (i + 1) && mbyte(i) != 8'(i * 7)) bad++;
        chk("R6", "510 write mismatches", bad, 0);
        chk("R6", "510 write done", n_done, 1);

        // R3 boundary: 512-byte read accepted
        clear_obs();
        put_hdr(3'd3, 0, 512); end_buf();
        for (int i = 0; i < 512; i++) push_slave(8'(i * 5 + 1));
        issue(4'd1, 4'd0, 4'd0);
        wait_idle();
        bad = 0;
        for (int i = 0; i < 512; i++) begin
            get_buf(i, v);
            if (v != 8'(i * 5 + 1)) bad++;
        end
        chk("R3", "512 read mismatches", bad, 0);
        chk("R3", "512 read done", n_done, 1);

        // R9 start on trigger
        clear_obs();
        put_hdr(3'd2, 0, 1); put_buf(2, 8'h5A); end_buf();
        issue(4'd2, 4'd1, 4'd3);
        repeat (30) @(negedge clk);
        chk("R9", "waiting busy/cs", int'(busy) * 10 + int'(cs_lines != 0), 10);
        trig = 1; @(negedge clk); trig = 0;
        wait_idle();
        chk("R9", "byte after trigger", mbits.size() == 8 ? mbyte(0) : -1, 8'h5A);
        chk("R9", "done and line", n_done * 1000 + cs_lines, 1002);

        // R10 halt at byte boundary
        clear_obs();
        put_hdr(3'd2, 0, 4);
        for (int i = 0; i < 4; i++) put_buf(2 + i, 8'hC0 + 8'(i));
        end_buf();
        issue(4'd1, 4'd0, 4'd0);
        while (nrise < 3) @(negedge clk);
        issue(4'd3, 4'd0, 4'd0);
        wait_idle();
        chk("R10", "bits before stop", mbits.size(), 8);
        chk("R10", "no done, idle", n_done * 10 + int'(busy), 0);
        chk("R10", "cs released", cs_n, 8'hFF);

        // R11 flush stops at once
        clear_obs();
        put_hdr(3'd2, 0, 4); end_buf();
        issue(4'd1, 4'd0, 4'd0);
        while (nrise < 3) @(negedge clk);
        issue(4'd4, 4'd0, 4'd0);
        chk("R11", "busy/cs right after flush", int'(busy) * 1000 + cs_n, 255);
        bad = nrise;
        repeat (40) @(negedge clk);
        chk("R11", "no later edges", nrise, bad);
        chk("R11", "no done", n_done, 0);

        // R13 commands ignored while busy
        clear_obs();
        put_hdr(3'd2, 0, 2); put_buf(2, 8'h11); put_buf(3, 8'h22); end_buf();
        issue(4'd1, 4'd0, 4'd6);
        while (nrise < 2) @(negedge clk);
        issue(4'd1, 4'd3, 4'd9);
        issue(4'd2, 4'd2, 4'd9);
        wait_idle();
        chk("R13", "bits", mbits.size(), 16);
        chk("R13", "bytes", mbits.size() == 16 ? {mbyte(0), mbyte(1)} : 0, 16'h1122);
        chk("R13", "done/line/profile", n_done * 1000 + cs_lines * 10 + prof_sel, 1016);

        // R14 and R8 per-clock invariants over the whole run
        chk("R14", "per-clock violations", viol, 0);
        summary();
    end
endmodule